// File: doc/BRIEF.md
# Victim Line Buffer with FIFO Age Order and Swap-on-Hit

This block is a small, fully associative buffer of line tags placed next to a first-level cache tag controller. Whenever the first-level cache misses, the controller presents the missing byte address. The block strips the line-offset bits and compares the remaining line address against every occupied entry at the same time. On a hit, the matching entry leaves the buffer, because it moves into the first-level cache. The line that the first-level cache evicts to make room then enters the buffer in exchange. On a miss, the evicted line is still inserted. If the buffer is full, its oldest entry is discarded to make room.

Entries are kept in age order: slot 0 holds the oldest entry and new entries go at the top. When a hit removes an entry from the middle, the younger entries slide down one slot, so the age order of the entries that remain is preserved. Entries never hold modified data, so no dirty state is stored. The block reports hit or miss for every lookup and keeps running counts of lookups and hits. With zero entries configured, the block answers every lookup as "not accessed".

Top module: `victim_swap_buf`

## Requirements
- R1: After reset, the buffer is empty, `rsp_valid`, `rsp_hit` and `rsp_skip` are 0, and both counters read 0.
- R2: A lookup (`req_valid`=1) produces `rsp_valid`=1 one cycle later. `rsp_hit` is 1 exactly when the line address `req_addr >> OFS_W` equals an occupied entry, and at most one entry ever matches.
- R3: On a hit, the matching line is removed, so an immediate second lookup of it without a reinsertion misses.
- R4: On a hit with `evict_valid`=1, the line `evict_addr >> OFS_W` is inserted, and a later lookup of that line hits.
- R5: On a miss with `evict_valid`=1 and fewer than NUM_ENT entries, the evicted line fills a free slot and no entry is discarded.
- R6: On a miss with `evict_valid`=1 and the buffer full, the oldest entry is discarded and the evicted line is inserted as the youngest.
- R7: After a hit removes an entry, the remaining entries keep their relative age, so the next discard takes the oldest survivor.
- R8: A lookup with `evict_valid`=0 inserts nothing, and the entries other than a hit line are unchanged.
- R9: `access_cnt` increments by one for each lookup and `hit_cnt` by one for each hit. Both are visible in the same cycle as the response.
- R10: With NUM_ENT=0, every lookup gives `rsp_valid`=1, `rsp_skip`=1 and `rsp_hit`=0, and both counters stay 0.
- R11: In a cycle without a lookup, `evict_valid` is ignored, and `rsp_valid` is 0 in the next cycle.
- R12: Address bits below OFS_W take no part in the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request from a first-level miss |
| req_addr | input | ADDR_W | Byte address of the missing line |
| evict_valid | input | 1 | The first-level cache evicts a valid line with this lookup |
| evict_addr | input | ADDR_W | Byte address of the evicted line |
| rsp_valid | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit | output | 1 | The lookup found its line |
| rsp_skip | output | 1 | The buffer is configured with zero entries and was not accessed |
| access_cnt | output | CNT_W | Number of lookups served |
| hit_cnt | output | CNT_W | Number of lookup hits |

## Verification
Each lookup is registered at the clock edge that samples it. Its response, the updated counters and the updated entries all become visible in the following cycle, and the next lookup already sees the updated contents. The bench drives each lookup on a falling edge and reads the response and counters one full cycle later, on the next falling edge. It compares them against its own age-ordered list model, which it updates only after the check. A directed sequence covers fill, swap, compaction and discard. A long pseudo-random sweep over eight line addresses with varied offsets then runs a zero-entry instance in parallel.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;

  // Line address of a byte address: the offset bits are shifted out.
  function automatic logic [63:0] line_of(input logic [63:0] addr, input int unsigned ofs_w);
    return addr >> ofs_w;
  endfunction

  // Position of the lowest set bit, 0 when none is set.
  function automatic int lowest_set(input logic [7:0] v);
    int r;
    r = 0;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

endpackage

// File: rtl/vbuf_match.sv
module vbuf_match #(
  parameter int SLOTS = 4,
  parameter int TAG_W = 58,
  parameter int OCC_W = 3,
  parameter int IDX_W = 2
) (
  input  logic [SLOTS-1:0][TAG_W-1:0] lines,
  input  logic [OCC_W-1:0]            occ,
  input  logic [TAG_W-1:0]            key,
  output logic [SLOTS-1:0]            match_vec,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    assign match_vec[i] = (i < int'(occ)) && (lines[i] == key);
  end

  assign hit     = |match_vec;
  assign hit_idx = IDX_W'(vbuf_pkg::lowest_set(8'(match_vec)));
endmodule

// File: rtl/vbuf_store.sv
module vbuf_store #(
  parameter int NUM_ENT = 4,
  parameter int SLOTS   = 4,
  parameter int TAG_W   = 58,
  parameter int OCC_W   = 3,
  parameter int IDX_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        hit,
  input  logic [IDX_W-1:0]            hit_idx,
  input  logic                        evict_valid,
  input  logic [TAG_W-1:0]            evict_line,
  output logic [SLOTS-1:0][TAG_W-1:0] lines,
  output logic [OCC_W-1:0]            occ,
  output logic                        ins_fire,
  output logic                        drop_fire
);
  logic [SLOTS-1:0][TAG_W-1:0] nl;
  logic [OCC_W-1:0]            no;

  always_comb begin
    nl        = lines;
    no        = occ;
    ins_fire  = 1'b0;
    drop_fire = 1'b0;
    if (req_valid) begin
      if (hit) begin
        // close the gap left by the leaving line; younger entries slide down
        for (int i = 0; i < SLOTS - 1; i++)
          if (i >= int'(hit_idx)) nl[i] = lines[i+1];
        no = occ - 1'b1;
      end
      if (evict_valid) begin
        ins_fire = 1'b1;
        if (int'(no) == NUM_ENT) begin
          drop_fire = 1'b1;
          for (int i = 0; i < SLOTS - 1; i++) nl[i] = nl[i+1];
          nl[SLOTS-1] = evict_line;
        end else begin
          for (int i = 0; i < SLOTS; i++)
            if (i == int'(no)) nl[i] = evict_line;
          no = no + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ   <= '0;
      lines <= '0;
    end else begin
      occ   <= no;
      lines <= nl;
    end
  end
endmodule

// File: rtl/vbuf_stats.sv
module vbuf_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_ev,
  input  logic             hit_ev,
  output logic [CNT_W-1:0] access_cnt,
  output logic [CNT_W-1:0] hit_cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      access_cnt <= '0;
      hit_cnt    <= '0;
    end else begin
      if (acc_ev) access_cnt <= access_cnt + 1'b1;
      if (hit_ev) hit_cnt    <= hit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/victim_swap_buf.sv
module victim_swap_buf #(
  parameter int NUM_ENT = 4,
  parameter int ADDR_W  = 64,
  parameter int OFS_W   = 6,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_skip,
  output logic [CNT_W-1:0]  access_cnt,
  output logic [CNT_W-1:0]  hit_cnt
);
  localparam int   TAG_W  = ADDR_W - OFS_W;
  localparam int   SLOTS  = (NUM_ENT < 1) ? 1 : NUM_ENT;
  localparam int   OCC_W  = (NUM_ENT < 1) ? 1 : $clog2(NUM_ENT + 1);
  localparam int   IDX_W  = (SLOTS < 2) ? 1 : $clog2(SLOTS);
  localparam logic BYPASS = (NUM_ENT == 0);

  // named internal events, observed by the bound checker
  logic                        lk_hit;
  logic                        ins_fire;
  logic                        drop_fire;
  logic [OCC_W-1:0]            occ;
  logic [SLOTS-1:0]            match_vec;
  logic [IDX_W-1:0]            hit_idx;
  logic [SLOTS-1:0][TAG_W-1:0] lines;
  logic [TAG_W-1:0]            req_line;
  logic [TAG_W-1:0]            evict_line;

  assign req_line   = TAG_W'(vbuf_pkg::line_of(64'(req_addr), OFS_W));
  assign evict_line = TAG_W'(vbuf_pkg::line_of(64'(evict_addr), OFS_W));

  if (NUM_ENT > 0) begin : g_buf
    vbuf_match #(.SLOTS(SLOTS), .TAG_W(TAG_W), .OCC_W(OCC_W), .IDX_W(IDX_W)) u_match (
      .lines(lines), .occ(occ), .key(req_line),
      .match_vec(match_vec), .hit(lk_hit), .hit_idx(hit_idx)
    );
    vbuf_store #(.NUM_ENT(NUM_ENT), .SLOTS(SLOTS), .TAG_W(TAG_W), .OCC_W(OCC_W), .IDX_W(IDX_W)) u_store (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(lk_hit), .hit_idx(hit_idx),
      .evict_valid(evict_valid), .evict_line(evict_line),
      .lines(lines), .occ(occ), .ins_fire(ins_fire), .drop_fire(drop_fire)
    );
  end else begin : g_none
    assign match_vec = '0;
    assign lk_hit    = 1'b0;
    assign hit_idx   = '0;
    assign lines     = '0;
    assign occ       = '0;
    assign ins_fire  = 1'b0;
    assign drop_fire = 1'b0;
  end

  vbuf_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .acc_ev(req_valid && !BYPASS), .hit_ev(req_valid && lk_hit),
    .access_cnt(access_cnt), .hit_cnt(hit_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_skip  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && lk_hit;
      rsp_skip  <= req_valid && BYPASS;
    end
  end
endmodule

// File: rtl/vbuf_chk.sv
module vbuf_chk #(
  parameter int NUM_ENT = 4,
  parameter int SLOTS   = 4,
  parameter int OCC_W   = 3,
  parameter int CNT_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             evict_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_skip,
  input logic [CNT_W-1:0] hit_cnt,
  input logic             lk_hit,
  input logic             drop_fire,
  input logic [OCC_W-1:0] occ,
  input logic [SLOTS-1:0] match_vec
);
  AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n) rsp_hit |-> rsp_valid); // R2
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
  AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match_vec)); // R2
  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R11
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) int'(occ) <= NUM_ENT); // R5
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    drop_fire |-> (int'(occ) == NUM_ENT) && !lk_hit); // R6
  AST_HIT_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && lk_hit && !evict_valid) |=> int'(occ) == int'($past(occ)) - 1); // R3
  AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lk_hit && evict_valid && int'(occ) < NUM_ENT) |=> int'(occ) == int'($past(occ)) + 1); // R5
  AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> hit_cnt == $past(hit_cnt) + 1'b1); // R9
  AST_SKIP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) rsp_skip |-> !rsp_hit); // R10
endmodule

bind victim_swap_buf vbuf_chk #(.NUM_ENT(NUM_ENT), .SLOTS(SLOTS), .OCC_W(OCC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .evict_valid(evict_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_skip(rsp_skip), .hit_cnt(hit_cnt),
  .lk_hit(lk_hit), .drop_fire(drop_fire), .occ(occ), .match_vec(match_vec)
);

// File: tb/sim_victim_swap_buf.sv
`timescale 1ns/1ps
module sim_victim_swap_buf;
  localparam int OFS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, evict_valid = 1'b0;
  logic [63:0] req_addr = '0, evict_addr = '0;
  logic rsp_valid, rsp_hit, rsp_skip;
  logic [15:0] access_cnt, hit_cnt;
  logic rsp1_valid, rsp1_hit, rsp1_skip;
  logic [15:0] acc1_cnt, hit1_cnt;

  int checks = 0, errors = 0;
  longint m[4];
  int mcnt = 0;
  int exp_acc = 0, exp_hit = 0;
  int seed = 32'h1d2c3b4a;

  always #2.5 clk = ~clk;

  victim_swap_buf u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_skip(rsp_skip),
    .access_cnt(access_cnt), .hit_cnt(hit_cnt)
  );

  victim_swap_buf #(.NUM_ENT(0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .rsp_valid(rsp1_valid), .rsp_hit(rsp1_hit), .rsp_skip(rsp1_skip),
    .access_cnt(acc1_cnt), .hit_cnt(hit1_cnt)
  );

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int mfind(input longint ln);
    int f;
    f = -1;
    for (int i = 0; i < mcnt; i++) if (m[i] == ln) f = i;
    return f;
  endfunction

  function automatic int rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return seed & 32'h7fffffff;
  endfunction

  task automatic do_acc(input longint rl, input int ofs, input bit ev, input longint el, input string rq);
    int f;
    bit eh;
    f  = mfind(rl);
    eh = (f >= 0);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'(rl << OFS) | 64'(ofs);
    evict_valid = ev; evict_addr = 64'(el << OFS) | 64'((ofs * 7) % 64);
    @(negedge clk);
    req_valid = 1'b0; evict_valid = 1'b0;
    if (eh) exp_hit++;
    exp_acc++;
    chk(rsp_valid && (rsp_hit == eh), rq, {rsp_valid, rsp_hit}, {1'b1, eh});
    chk(access_cnt == 16'(exp_acc) && hit_cnt == 16'(exp_hit), "R9",
        {access_cnt, hit_cnt}, {16'(exp_acc), 16'(exp_hit)});
    chk(rsp1_valid && rsp1_skip && !rsp1_hit && acc1_cnt == 0 && hit1_cnt == 0, "R10",
        {rsp1_valid, rsp1_skip, rsp1_hit, acc1_cnt, hit1_cnt}, {3'b110, 32'd0});
    // reference list update: remove on hit, then append the evicted line
    if (eh) begin
      for (int i = f; i < mcnt - 1; i++) m[i] = m[i+1];
      mcnt--;
    end
    if (ev) begin
      if (mcnt == 4) begin
        for (int i = 0; i < 3; i++) m[i] = m[i+1];
        m[3] = el;
      end else begin
        m[mcnt] = el;
        mcnt++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !rsp_hit && !rsp_skip && access_cnt == 0 && hit_cnt == 0, "R1",
        {rsp_valid, rsp_hit, rsp_skip, access_cnt, hit_cnt}, 0);
    chk(!rsp1_valid && acc1_cnt == 0, "R1", {rsp1_valid, acc1_cnt}, 0);

    do_acc(10, 0, 1, 1, "R5");   // fill: [1]
    do_acc(11, 3, 1, 2, "R5");   // [1 2]
    do_acc(12, 9, 1, 3, "R5");   // [1 2 3]
    do_acc(13, 1, 1, 4, "R5");   // [1 2 3 4]
    do_acc(2, 5, 1, 5, "R7");    // hit mid: [1 3 4 5]
    do_acc(2, 0, 0, 0, "R3");    // removed line misses
    do_acc(20, 2, 1, 6, "R6");   // full miss drops 1: [3 4 5 6]
    do_acc(1, 0, 0, 0, "R6");    // oldest gone
    do_acc(3, 0, 0, 0, "R7");    // oldest survivor hits: [4 5 6]
    do_acc(5, 4, 0, 0, "R4");    // swapped-in line hits: [4 6]
    do_acc(30, 8, 0, 0, "R8");   // miss without eviction inserts nothing
    do_acc(4, 17, 0, 0, "R8");   // contents kept: [6]
    do_acc(6, 63, 0, 0, "R12");  // offset bits ignored: []

    // eviction without a lookup is ignored
    @(negedge clk);
    evict_valid = 1'b1; evict_addr = 64'(9 << OFS);
    @(negedge clk);
    evict_valid = 1'b0;
    chk(!rsp_valid && !rsp1_valid, "R11", {rsp_valid, rsp1_valid}, 0);
    do_acc(9, 0, 0, 0, "R11");

    // sweep over eight lines with varied offsets and evictions
    for (int n = 0; n < 1500; n++) begin
      longint rl, el;
      bit ev;
      int tries;
      rl = longint'(rnd() % 8);
      ev = rnd() % 3 != 0;
      el = 0;
      tries = 0;
      if (ev) begin
        el = longint'(rnd() % 8);
        while ((el == rl || mfind(el) >= 0) && tries < 16) begin
          el = (el + 1) % 8;
          tries++;
        end
        if (el == rl || mfind(el) >= 0) ev = 1'b0;
      end
      do_acc(rl, rnd() % 64, ev, el, "R2");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule